// File: doc/BRIEF.md
# Power Monitor Serial Register and Readback Front End

This block is the two-wire serial slave that sits between a host bus and the internal conversion sequencer and alert controller of a power monitor. It filters the clock and data lines, finds START and STOP conditions, and matches its 7-bit slave address. It then turns write transactions into register updates and serves read transactions from a packed snapshot of the latest voltage and current results or the status byte.

A write whose first data byte has its top bit clear loads the command register. The command register selects the channels to convert, whether conversions run once or continuously, and whether reads return status. A first byte with its top bit set instead names one of three extended registers, and the byte that follows is written there. Reads return two or three bytes, depending on which channels the command register enables. While a one-shot conversion is still pending, a read is refused at the address byte.

The sequencer and the alert controller see plain register outputs. The command register also has a one-cycle strobe that marks each load. Open-drain pads are outside the block: it takes the resolved line levels and drives only a pull-low enable for the data line.

Top module: `pm_i2c_front`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {5'b01011, addr_strap}. Any other address is not acknowledged, and the block then stays silent until the next START.
- R2: In a write, a first data byte with bit 7 = 0 loads its bits 6:0 into cmd_reg and pulses cmd_wr for one cycle. cmd_reg changes at no other time.
- R3: In a write, a first data byte with bit 7 = 1 selects an extended register by its bits 1:0: 01 selects alert_en, 10 selects alert_th and 11 selects ctrl_reg. The second data byte is stored in the selected register. Selector 00, and every data byte after the second, changes nothing.
- R4: An address-only write followed by STOP is acknowledged and leaves every register output unchanged.
- R5: The voltage channel counts as enabled when cmd_reg bit 0 or bit 1 is set. The current channel counts as enabled when bit 2 or bit 3 is set. With both enabled, a read returns three bytes in this order: volt[11:4], curr[11:4], {volt[3:0], curr[3:0]}.
- R6: With only the current channel enabled, a read returns curr[11:4] and then {curr[3:0], 4'h0}. With only the voltage channel enabled, or with neither enabled, the same layout is used with volt.
- R7: When cmd_reg bit 6 is set, the first read byte is status_byte and the following bytes are 8'h00, whatever channels are enabled.
- R8: While oneshot_pending is high, a read address byte is not acknowledged. A write address byte is still acknowledged.
- R9: Bits are shifted MSB first, and address bit 0 selects the direction (0 = write, 1 = read). Read bytes beyond the packed length are 8'h00. A master no-acknowledge ends the read, and the data line is then released.
- R10: A START or a STOP at any bit position abandons the byte in progress. After a STOP the data line is released, and after a START the next byte is decoded as an address.
- R11: The read bytes are captured when the read address is acknowledged. Changes to volt_code, curr_code or status_byte during the read do not alter the bytes returned.
- R12: After reset, cmd_reg = 7'h00, alert_en = 8'h04, alert_th = 8'hFF, ctrl_reg = 8'h00, and sda_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull the data line low when high |
| addr_strap | input | 2 | Low two bits of the slave address |
| oneshot_pending | input | 1 | A single conversion is still in progress |
| volt_code | input | 12 | Latest voltage conversion result |
| curr_code | input | 12 | Latest current conversion result |
| status_byte | input | 8 | Alert status from the alert controller |
| cmd_reg | output | 7 | Command register |
| cmd_wr | output | 1 | One-cycle strobe when cmd_reg is loaded |
| alert_en | output | 8 | Alert enable register |
| alert_th | output | 8 | Alert threshold register |
| ctrl_reg | output | 8 | Control register |

## Verification
The address decoder is swept over all 128 seven-bit addresses for one strap setting, and the matching address is checked for every strap. This separates a correct compare from one that ignores strap bits or fixed bits. Reads are repeated for several code pairs in each of the five channel and status settings, and each read fetches three bytes. A swapped nibble, a wrong byte order or a stale third byte therefore shows up against the arithmetic expectation. Separate transactions cover the extended-register selector values including 00, trailing write bytes, quick commands, pending one-shot refusal, START and STOP in mid-byte, and a code change in the middle of a read that must not reach the returned bytes.

// File: rtl/pm_i2c_pkg.sv
package pm_i2c_pkg;

    localparam int          CODE_W   = 12;
    localparam int          NIB_W    = CODE_W - 8;
    localparam logic [4:0]  ADDR_HI  = 5'b01011;

    localparam logic [6:0]  CMD_RST  = 7'h00;
    localparam logic [7:0]  AEN_RST  = 8'h04;
    localparam logic [7:0]  ATH_RST  = 8'hFF;
    localparam logic [7:0]  CTL_RST  = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eng_state_t;

    typedef enum logic [1:0] {
        EXT_NONE = 2'b00,
        EXT_AEN  = 2'b01,
        EXT_ATH  = 2'b10,
        EXT_CTL  = 2'b11
    } ext_sel_t;

    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
    } rd_pack_t;

    function automatic rd_pack_t pack_read(
        input logic [6:0]        cmd,
        input logic [CODE_W-1:0] v,
        input logic [CODE_W-1:0] i,
        input logic [7:0]        st
    );
        rd_pack_t p;
        logic v_on, i_on;
        v_on = cmd[0] | cmd[1];
        i_on = cmd[2] | cmd[3];
        p = '0;
        if (cmd[6]) begin
            p.b0 = st;
        end else if (v_on && i_on) begin
            p.b0 = v[CODE_W-1:NIB_W];
            p.b1 = i[CODE_W-1:NIB_W];
            p.b2 = {v[NIB_W-1:0], i[NIB_W-1:0]};
        end else if (i_on) begin
            p.b0 = i[CODE_W-1:NIB_W];
            p.b1 = {i[NIB_W-1:0], {(8-NIB_W){1'b0}}};
        end else begin
            p.b0 = v[CODE_W-1:NIB_W];
            p.b1 = {v[NIB_W-1:0], {(8-NIB_W){1'b0}}};
        end
        return p;
    endfunction

    function automatic logic [7:0] pick_byte(input rd_pack_t p, input logic [1:0] k);
        case (k)
            2'd0:    return p.b0;
            2'd1:    return p.b1;
            2'd2:    return p.b2;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pm_i2c_line_filter.sv
module pm_i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MAJ_TAPS    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int HALF = MAJ_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [MAJ_TAPS-1:0]    taps_q;
    logic                   level_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            taps_q  <= '1;
            level_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], din};
            taps_q  <= {taps_q[MAJ_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            level_q <= ($countones(taps_q) > HALF);
            prev_q  <= level_q;
        end
    end

    assign level = level_q;
    assign rise  = level_q & ~prev_q;
    assign fall  = ~level_q & prev_q;

endmodule

// File: rtl/pm_i2c_byte_engine.sv
module pm_i2c_byte_engine
    import pm_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl,
    input  logic       sda,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [1:0] strap,
    input  logic       pending,
    input  rd_pack_t   snap,
    output logic       sda_oe,
    output logic       wr_valid,
    output logic [7:0] wr_data,
    output logic [1:0] wr_idx,
    output logic       addr_rd_ack,
    output logic       start_ev,
    output logic       stop_ev
);
    eng_state_t st_q;
    logic       is_addr_q;
    logic       rw_q;
    logic [3:0] cnt_q;
    logic [7:0] sr_q;
    logic [7:0] tx_q;
    logic [1:0] ridx_q;
    logic [1:0] widx_q;
    logic       nack_q;
    logic       addr_hit;

    assign start_ev = scl & sda_fall;
    assign stop_ev  = scl & sda_rise;
    assign addr_hit = (sr_q[7:1] == {ADDR_HI, strap});

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            is_addr_q   <= 1'b0;
            rw_q        <= 1'b0;
            cnt_q       <= '0;
            sr_q        <= '0;
            tx_q        <= 8'hFF;
            ridx_q      <= '0;
            widx_q      <= '0;
            nack_q      <= 1'b0;
            wr_valid    <= 1'b0;
            wr_data     <= '0;
            wr_idx      <= '0;
            addr_rd_ack <= 1'b0;
        end else begin
            wr_valid    <= 1'b0;
            addr_rd_ack <= 1'b0;
            if (start_ev) begin
                st_q      <= ST_RX;
                is_addr_q <= 1'b1;
                cnt_q     <= '0;
                widx_q    <= '0;
                ridx_q    <= '0;
            end else if (stop_ev) begin
                st_q <= ST_IDLE;
            end else begin
                case (st_q)
                    ST_RX: begin
                        if (scl_rise && cnt_q < 4'd8) begin
                            sr_q  <= {sr_q[6:0], sda};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            if (is_addr_q) begin
                                if (addr_hit && !(sr_q[0] && pending)) begin
                                    st_q        <= ST_ACK;
                                    rw_q        <= sr_q[0];
                                    addr_rd_ack <= sr_q[0];
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end else begin
                                wr_valid <= 1'b1;
                                wr_data  <= sr_q;
                                wr_idx   <= widx_q;
                                widx_q   <= (widx_q == 2'd3) ? widx_q : widx_q + 2'd1;
                                st_q     <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            is_addr_q <= 1'b0;
                            cnt_q     <= '0;
                            if (rw_q) begin
                                st_q   <= ST_TX;
                                tx_q   <= pick_byte(snap, ridx_q);
                                ridx_q <= (ridx_q == 2'd3) ? ridx_q : ridx_q + 2'd1;
                            end else begin
                                st_q <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt_q == 4'd7) begin
                                st_q  <= ST_MACK;
                                cnt_q <= '0;
                            end else begin
                                tx_q  <= {tx_q[6:0], 1'b1};
                                cnt_q <= cnt_q + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            nack_q <= sda;
                        end else if (scl_fall) begin
                            if (nack_q) begin
                                st_q <= ST_IDLE;
                            end else begin
                                st_q   <= ST_TX;
                                tx_q   <= pick_byte(snap, ridx_q);
                                ridx_q <= (ridx_q == 2'd3) ? ridx_q : ridx_q + 2'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = (st_q == ST_ACK) | ((st_q == ST_TX) & ~tx_q[7]);

endmodule

// File: rtl/pm_i2c_regfile.sv
module pm_i2c_regfile
    import pm_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        wr_idx,
    input  logic              addr_rd_ack,
    input  logic [CODE_W-1:0] volt,
    input  logic [CODE_W-1:0] curr,
    input  logic [7:0]        status,
    output logic [6:0]        cmd,
    output logic              cmd_wr,
    output logic [7:0]        alert_en,
    output logic [7:0]        alert_th,
    output logic [7:0]        ctrl,
    output rd_pack_t          snap
);
    ext_sel_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= CMD_RST;
            cmd_wr   <= 1'b0;
            alert_en <= AEN_RST;
            alert_th <= ATH_RST;
            ctrl     <= CTL_RST;
            sel_q    <= EXT_NONE;
            snap     <= '0;
        end else begin
            cmd_wr <= 1'b0;
            if (addr_rd_ack) begin
                snap <= pack_read(cmd, volt, curr, status);
            end
            if (wr_valid) begin
                if (wr_idx == 2'd0) begin
                    if (wr_data[7]) begin
                        sel_q <= ext_sel_t'(wr_data[1:0]);
                    end else begin
                        sel_q  <= EXT_NONE;
                        cmd    <= wr_data[6:0];
                        cmd_wr <= 1'b1;
                    end
                end else if (wr_idx == 2'd1) begin
                    case (sel_q)
                        EXT_AEN: alert_en <= wr_data;
                        EXT_ATH: alert_th <= wr_data;
                        EXT_CTL: ctrl     <= wr_data;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pm_i2c_front.sv
module pm_i2c_front
    import pm_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAJ_TAPS    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        addr_strap,
    input  logic              oneshot_pending,
    input  logic [CODE_W-1:0] volt_code,
    input  logic [CODE_W-1:0] curr_code,
    input  logic [7:0]        status_byte,
    output logic [6:0]        cmd_reg,
    output logic              cmd_wr,
    output logic [7:0]        alert_en,
    output logic [7:0]        alert_th,
    output logic [7:0]        ctrl_reg
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_line;
    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] up;
    logic [N_LINES-1:0] dn;

    assign raw_line = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        pm_i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .MAJ_TAPS   (MAJ_TAPS)
        ) u_flt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_line[g]),
            .level(lvl[g]),
            .rise (up[g]),
            .fall (dn[g])
        );
    end

    logic       scl_lvl;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic [1:0] wr_idx;
    logic       addr_rd_ack;
    logic       start_ev;
    logic       stop_ev;
    rd_pack_t   snap;

    assign scl_lvl = lvl[0];

    pm_i2c_byte_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .scl        (lvl[0]),
        .sda        (lvl[1]),
        .scl_rise   (up[0]),
        .scl_fall   (dn[0]),
        .sda_rise   (up[1]),
        .sda_fall   (dn[1]),
        .strap      (addr_strap),
        .pending    (oneshot_pending),
        .snap       (snap),
        .sda_oe     (sda_oe),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_idx     (wr_idx),
        .addr_rd_ack(addr_rd_ack),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev)
    );

    pm_i2c_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_idx     (wr_idx),
        .addr_rd_ack(addr_rd_ack),
        .volt       (volt_code),
        .curr       (curr_code),
        .status     (status_byte),
        .cmd        (cmd_reg),
        .cmd_wr     (cmd_wr),
        .alert_en   (alert_en),
        .alert_th   (alert_th),
        .ctrl       (ctrl_reg),
        .snap       (snap)
    );

endmodule

// File: rtl/pm_i2c_front_chk.sv
module pm_i2c_front_chk
    import pm_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       cmd_wr,
    input logic [6:0] cmd_reg,
    input logic       wr_valid,
    input logic [7:0] alert_en,
    input logic [7:0] alert_th,
    input logic [7:0] ctrl_reg,
    input logic       addr_rd_ack,
    input logic       oneshot_pending,
    input rd_pack_t   snap,
    input logic       stop_ev
);
    AST_CMD_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |-> $stable(cmd_reg)); // R2

    AST_EXT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> ($stable(alert_en) && $stable(alert_th) && $stable(ctrl_reg))); // R3

    AST_READ_REFUSED_PENDING: assert property (@(posedge clk) disable iff (rst)
        addr_rd_ack |-> !$past(oneshot_pending)); // R8

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f); // R9

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe); // R10

    AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (rst)
        !addr_rd_ack |=> $stable(snap)); // R11

endmodule

bind pm_i2c_front pm_i2c_front_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .scl_f          (scl_lvl),
    .sda_oe         (sda_oe),
    .cmd_wr         (cmd_wr),
    .cmd_reg        (cmd_reg),
    .wr_valid       (wr_valid),
    .alert_en       (alert_en),
    .alert_th       (alert_th),
    .ctrl_reg       (ctrl_reg),
    .addr_rd_ack    (addr_rd_ack),
    .oneshot_pending(oneshot_pending),
    .snap           (snap),
    .stop_ev        (stop_ev)
);

// File: tb/test_pm_i2c_front.sv
module test_pm_i2c_front;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'd0;
    logic        pending = 1'b0;
    logic [11:0] vcode = '0;
    logic [11:0] icode = '0;
    logic [7:0]  stat = 8'h00;
    logic        sda_oe;
    logic [6:0]  cmd_reg;
    logic        cmd_wr;
    logic [7:0]  alert_en, alert_th, ctrl_reg;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_i2c_front i_pm_i2c_front (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_strap(strap), .oneshot_pending(pending), .volt_code(vcode),
        .curr_code(icode), .status_byte(stat), .cmd_reg(cmd_reg), .cmd_wr(cmd_wr),
        .alert_en(alert_en), .alert_th(alert_th), .ctrl_reg(ctrl_reg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic bus_bit(input logic b, output logic smp);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        smp = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int k = 7; k >= 0; k--) bus_bit(d[k], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] d);
        logic s;
        for (int k = 7; k >= 0; k--) begin
            bus_bit(1'b1, s);
            d[k] = s;
        end
        bus_bit(last, s);
    endtask

    task automatic wr_txn(input logic [7:0] b0, input logic [7:0] b1, input int n);
        logic a;
        bus_start();
        send_byte({5'b01011, strap, 1'b0}, a);
        if (n > 0) send_byte(b0, a);
        if (n > 1) send_byte(b1, a);
        bus_stop();
    endtask

    function automatic logic [23:0] expect_rd(input logic [6:0] c, input logic [11:0] v,
                                              input logic [11:0] i, input logic [7:0] s);
        int von, ion;
        von = (c[0] | c[1]) ? 1 : 0;
        ion = (c[2] | c[3]) ? 1 : 0;
        if (c[6]) return {s, 16'h0000};
        if (von == 1 && ion == 1) return {8'(v / 16), 8'(i / 16), 8'((v % 16) * 16 + (i % 16))};
        if (ion == 1) return {8'(i / 16), 8'((i % 16) * 16), 8'h00};
        return {8'(v / 16), 8'((v % 16) * 16), 8'h00};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d0, d1, d2;
        logic [23:0] e;
        logic [6:0] modes [5];
        modes[0] = 7'h05; modes[1] = 7'h01; modes[2] = 7'h08;
        modes[3] = 7'h00; modes[4] = 7'h45;

        tick(5);
        rst = 1'b0;
        tick(5);
        // R12 reset values
        chk("R12 cmd", cmd_reg, 0);
        chk("R12 aen", alert_en, 8'h04);
        chk("R12 ath", alert_th, 8'hFF);
        chk("R12 ctl", ctrl_reg, 0);
        chk("R12 sda", sda_oe, 0);

        // R1 full address sweep for strap 2, plus matching address per strap
        strap = 2'd2;
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            bus_stop();
            chk("R1 sweep", a, (ad == 7'h2E) ? 1 : 0);
        end
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            bus_start();
            send_byte({5'b01011, 2'(s), 1'b0}, a);
            bus_stop();
            chk("R1 strap", a, 1);
        end
        strap = 2'd1;

        // R4 quick command changes nothing
        wr_txn(8'h00, 8'h00, 0);
        chk("R4 cmd", cmd_reg, 0);
        chk("R4 aen", alert_en, 8'h04);

        // R2 command write
        wr_txn(8'h2A, 8'h00, 1);
        chk("R2 cmd", cmd_reg, 7'h2A);

        // R3 extended writes
        wr_txn(8'h81, 8'h13, 2);
        chk("R3 aen", alert_en, 8'h13);
        wr_txn(8'h82, 8'h7A, 2);
        chk("R3 ath", alert_th, 8'h7A);
        wr_txn(8'h83, 8'h01, 2);
        chk("R3 ctl", ctrl_reg, 8'h01);
        wr_txn(8'h80, 8'h55, 2);
        chk("R3 sel00 aen", alert_en, 8'h13);
        chk("R3 sel00 ath", alert_th, 8'h7A);
        chk("R3 sel00 ctl", ctrl_reg, 8'h01);
        chk("R3 sel00 cmd", cmd_reg, 7'h2A);
        bus_start();
        send_byte({5'b01011, strap, 1'b0}, a);
        send_byte(8'h82, a);
        send_byte(8'h40, a);
        send_byte(8'h99, a);
        bus_stop();
        chk("R3 trailing", alert_th, 8'h40);

        // R5 R6 R7 R9 read sweep
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 5; m++) begin
                vcode = 12'((k * 12'h2F1 + 12'h0A3) % 4096);
                icode = 12'((k * 12'h517 + 12'h03C) % 4096);
                stat  = 8'(8'hA5 ^ (k * 8'h11));
                wr_txn({1'b0, modes[m]}, 8'h00, 1);
                e = expect_rd(modes[m], vcode, icode, stat);
                bus_start();
                send_byte({5'b01011, strap, 1'b1}, a);
                recv_byte(1'b0, d0);
                recv_byte(1'b0, d1);
                recv_byte(1'b1, d2);
                bus_stop();
                chk("R5/R6/R7 byte0 R9", d0, e[23:16]);
                chk("R5/R6/R7 byte1 R9", d1, e[15:8]);
                chk("R5/R6/R7 byte2 R9", d2, e[7:0]);
            end
        end

        // R9 release after master NACK
        wr_txn(8'h01, 8'h00, 1);
        bus_start();
        send_byte({5'b01011, strap, 1'b1}, a);
        recv_byte(1'b1, d0);
        for (int k = 0; k < 8; k++) begin
            bus_bit(1'b1, a);
            chk("R9 released", a, 1);
        end
        bus_stop();

        // R8 pending refusal
        pending = 1'b1;
        bus_start();
        send_byte({5'b01011, strap, 1'b1}, a);
        bus_stop();
        chk("R8 read nack", a, 0);
        bus_start();
        send_byte({5'b01011, strap, 1'b0}, a);
        bus_stop();
        chk("R8 write ack", a, 1);
        pending = 1'b0;
        bus_start();
        send_byte({5'b01011, strap, 1'b1}, a);
        recv_byte(1'b1, d0);
        bus_stop();
        chk("R8 read ack after", a, 1);

        // R11 snapshot
        wr_txn(8'h05, 8'h00, 1);
        vcode = 12'h123; icode = 12'h456;
        bus_start();
        send_byte({5'b01011, strap, 1'b1}, a);
        vcode = 12'hABC; icode = 12'hDEF;
        recv_byte(1'b0, d0);
        recv_byte(1'b0, d1);
        recv_byte(1'b1, d2);
        bus_stop();
        chk("R11 b0", d0, 8'h12);
        chk("R11 b1", d1, 8'h45);
        chk("R11 b2", d2, 8'h36);

        // R10 START and STOP mid-byte
        bus_start();
        bus_bit(1'b0, a); bus_bit(1'b1, a); bus_bit(1'b0, a);
        bus_start();
        send_byte({5'b01011, strap, 1'b0}, a);
        chk("R10 restart ack", a, 1);
        send_byte(8'h0C, a);
        bus_stop();
        chk("R10 restart cmd", cmd_reg, 7'h0C);
        bus_start();
        send_byte({5'b01011, strap, 1'b0}, a);
        bus_bit(1'b0, a); bus_bit(1'b1, a);
        bus_stop();
        chk("R10 stop release", sda_oe, 0);
        chk("R10 stop cmd", cmd_reg, 7'h0C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule